// File: doc/BRIEF.md
# Speculative Branch Queue Tagger

This block keeps track of conditional branches in a task graph that the decoder has walked past before they are resolved. The decoder predicts each branch statically with a single direction bit and keeps decoding down the predicted side. When it announces a branch, the block claims a free branch slot and stores two things there: the predicted direction and the address of the side that was not taken. It then hands the slot number back to the decoder as the branch tag.

While a branch is outstanding, every task the decoder writes into a queue marks that queue with the branch's tag. A queue can carry several tags at once.

When a branch becomes eligible, it is resolved with its tag and the real direction.
- If the prediction was right, its tag is removed from every queue and the slot is freed.
- If the prediction was wrong, every queue that carries the tag of this branch, or of any branch decoded after it, is flushed. All of those slots are freed, and the saved address is returned so the decoder can start again from there.

Top module: `spec_branch_tagger`

## Requirements
- R1: With fewer than NB branch slots busy, `br_tag` shows the lowest-numbered free slot. A branch announced while `br_stall` is low takes that slot and records its predicted direction (`br_dec_pred`, 1 = taken) and its alternate address.
- R2: `br_stall` is high while all NB slots are busy, and also in any cycle where `res_valid` is high. An announcement made while `br_stall` is high allocates nothing.
- R3: A queue write (`q_wr_valid`, queue `q_wr_idx`) adds every branch outstanding before the clock edge to that queue's tag set. A branch allocated in the same cycle as the write is not included.
- R4: A resolve whose `res_taken` equals the stored prediction frees the slot and removes its tag from all queues. The next cycle shows no flush and no redirect.
- R5: A resolve whose `res_taken` differs from the stored prediction raises `redir_valid` exactly one cycle later, with `redir_addr` equal to the saved alternate address. In every other cycle both outputs are zero.
- R6: One cycle after a mispredict, `flush_mask` bit q is 1 exactly when queue q carried the resolved branch or any branch allocated after it. Flushed queues lose all their tags. In every other cycle `flush_mask` is zero.
- R7: A mispredict frees the resolved slot and every slot allocated after it. Slots allocated before it stay busy with their tags intact.
- R8: A resolve that names a free slot is ignored: no flush, no redirect, and no change to any slot or queue tag.
- R9: A queue write in the same cycle as a resolve is tagged first and resolved second. So a write that picks up a mispredicted branch puts its queue into that flush.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_dec_valid | input | 1 | Decoder announces a branch |
| br_dec_pred | input | 1 | Predicted direction, 1 = taken |
| br_dec_alt | input | AW | Address of the side not predicted |
| br_tag | output | TW | Slot the next branch will take |
| br_stall | output | 1 | Branch announcement cannot be accepted |
| q_wr_valid | input | 1 | Decoder writes a task into a queue |
| q_wr_idx | input | QW | Queue being written |
| res_valid | input | 1 | A branch is being resolved |
| res_tag | input | TW | Tag of the resolved branch |
| res_taken | input | 1 | Actual direction, 1 = taken |
| flush_mask | output | NQ | Queues to discard (registered) |
| redir_valid | output | 1 | Restart decoding (registered) |
| redir_addr | output | AW | Restart address (registered) |

## Verification
Errors in slot state show up at the ports quickly:
- A wrong busy bit changes `br_tag` or `br_stall` in the very next cycle.
- A lost or stale prediction bit turns a correct resolve into a redirect, or the reverse, one cycle after that resolve.

Errors in queue state take longer to surface:
- A queue tag that is missing, or never cleared, shows up only at the next mispredict. The `flush_mask` for that cycle then has too few or too many bits set.
- A wrong age relation between branches likewise appears only at a mispredict. It shows as younger branches that survive, seen later as wrong `br_tag` values, or as older queues flushed by mistake.

The bench therefore runs nested branches, resolves out of order, and includes same-cycle write/resolve cases.

// File: rtl/sbt_pkg.sv
package sbt_pkg;

  // Index of the lowest clear bit among the first n bits of m (0 when none).
  function automatic int lowest_clear(input logic [31:0] m, input int n);
    int r;
    r = 0;
    for (int i = n - 1; i >= 0; i--) begin
      if (!m[i]) r = i;
    end
    return r;
  endfunction

  // One-hot mask of width up to 32 for index k.
  function automatic logic [31:0] bit_at(input int k);
    logic [31:0] m;
    m = '0;
    m[k] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/sbt_slot_table.sv
module sbt_slot_table #(
  parameter int NB = 4,
  parameter int AW = 16,
  localparam int TW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_en,
  input  logic [TW-1:0] alloc_tag,
  input  logic          alloc_pred,
  input  logic [AW-1:0] alloc_alt,
  input  logic          res_valid,
  input  logic [TW-1:0] res_tag,
  input  logic          res_taken,
  output logic [NB-1:0] busy,
  output logic [NB-1:0] kill_mask,
  output logic [NB-1:0] done_mask,
  output logic          hit,
  output logic          miss,
  output logic [AW-1:0] alt_sel
);
  import sbt_pkg::*;

  logic [NB-1:0] valid_q;
  logic [NB-1:0] pred_q;
  logic [AW-1:0] alt_q   [NB];
  logic [NB-1:0] older_q [NB];   // older_q[j][i]: slot i was live when j was taken
  logic [NB-1:0] younger;
  logic [NB-1:0] sel_hot;
  logic [NB-1:0] release_m;

  assign busy    = valid_q;
  assign sel_hot = NB'(bit_at(int'(res_tag)));
  assign hit     = res_valid && valid_q[res_tag];
  assign miss    = hit && (res_taken != pred_q[res_tag]);
  assign alt_sel = alt_q[res_tag];

  always_comb begin
    for (int j = 0; j < NB; j++) begin
      younger[j] = valid_q[j] && older_q[j][res_tag];
    end
    kill_mask = miss ? (younger | sel_hot) : '0;
    done_mask = (hit && !miss) ? sel_hot : '0;
    release_m = kill_mask | done_mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      pred_q  <= '0;
      for (int i = 0; i < NB; i++) begin
        alt_q[i]   <= '0;
        older_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NB; i++) begin
        older_q[i] <= older_q[i] & ~release_m;
        if (release_m[i]) valid_q[i] <= 1'b0;
        if (alloc_en && (alloc_tag == TW'(i))) begin
          valid_q[i] <= 1'b1;
          pred_q[i]  <= alloc_pred;
          alt_q[i]   <= alloc_alt;
          older_q[i] <= valid_q & ~release_m;
        end
      end
    end
  end

endmodule

// File: rtl/sbt_queue_tags.sv
module sbt_queue_tags #(
  parameter int NQ = 8,
  parameter int NB = 4,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [QW-1:0] wr_idx,
  input  logic [NB-1:0] live_set,
  input  logic [NB-1:0] kill_mask,
  input  logic [NB-1:0] done_mask,
  output logic [NQ-1:0] flush
);

  for (genvar q = 0; q < NQ; q++) begin : g_q
    logic [NB-1:0] tag_q;
    logic [NB-1:0] tag_pre;

    assign tag_pre  = tag_q | ((wr_valid && (wr_idx == QW'(q))) ? live_set : '0);
    assign flush[q] = |(tag_pre & kill_mask);

    always_ff @(posedge clk) begin
      if (!rst_n)        tag_q <= '0;
      else if (flush[q]) tag_q <= '0;
      else               tag_q <= tag_pre & ~done_mask & ~kill_mask;
    end
  end

endmodule

// File: rtl/sbt_redirect_reg.sv
module sbt_redirect_reg #(
  parameter int NQ = 8,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          miss,
  input  logic [NQ-1:0] flush_in,
  input  logic [AW-1:0] alt_in,
  output logic [NQ-1:0] flush_mask,
  output logic          redir_valid,
  output logic [AW-1:0] redir_addr
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flush_mask  <= '0;
      redir_valid <= 1'b0;
      redir_addr  <= '0;
    end else begin
      flush_mask  <= miss ? flush_in : '0;
      redir_valid <= miss;
      redir_addr  <= miss ? alt_in : '0;
    end
  end

endmodule

// File: rtl/spec_branch_tagger.sv
module spec_branch_tagger #(
  parameter int NB = 4,
  parameter int NQ = 8,
  parameter int AW = 16,
  localparam int TW = (NB > 1) ? $clog2(NB) : 1,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          br_dec_valid,
  input  logic          br_dec_pred,
  input  logic [AW-1:0] br_dec_alt,
  output logic [TW-1:0] br_tag,
  output logic          br_stall,
  input  logic          q_wr_valid,
  input  logic [QW-1:0] q_wr_idx,
  input  logic          res_valid,
  input  logic [TW-1:0] res_tag,
  input  logic          res_taken,
  output logic [NQ-1:0] flush_mask,
  output logic          redir_valid,
  output logic [AW-1:0] redir_addr
);
  import sbt_pkg::*;

  logic [NB-1:0] busy;
  logic [NB-1:0] kill_mask;
  logic [NB-1:0] done_mask;
  logic [NQ-1:0] flush_now;
  logic [AW-1:0] alt_sel;
  logic          table_full;
  // named internal events
  logic          ev_alloc;
  logic          ev_hit;
  logic          ev_miss;

  assign table_full = &busy;
  assign br_tag     = TW'(lowest_clear(32'(busy), NB));
  assign br_stall   = res_valid || table_full;
  assign ev_alloc   = br_dec_valid && !br_stall;

  sbt_slot_table #(.NB(NB), .AW(AW)) u_slots (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_en  (ev_alloc),
    .alloc_tag (br_tag),
    .alloc_pred(br_dec_pred),
    .alloc_alt (br_dec_alt),
    .res_valid (res_valid),
    .res_tag   (res_tag),
    .res_taken (res_taken),
    .busy      (busy),
    .kill_mask (kill_mask),
    .done_mask (done_mask),
    .hit       (ev_hit),
    .miss      (ev_miss),
    .alt_sel   (alt_sel)
  );

  sbt_queue_tags #(.NQ(NQ), .NB(NB)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (q_wr_valid),
    .wr_idx   (q_wr_idx),
    .live_set (busy),
    .kill_mask(kill_mask),
    .done_mask(done_mask),
    .flush    (flush_now)
  );

  sbt_redirect_reg #(.NQ(NQ), .AW(AW)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .miss       (ev_miss),
    .flush_in   (flush_now),
    .alt_in     (alt_sel),
    .flush_mask (flush_mask),
    .redir_valid(redir_valid),
    .redir_addr (redir_addr)
  );

endmodule

// File: rtl/sbt_checker.sv
module sbt_checker #(
  parameter int NB = 4,
  parameter int NQ = 8,
  parameter int AW = 16,
  localparam int TW = (NB > 1) ? $clog2(NB) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          br_dec_valid,
  input logic          br_stall,
  input logic [TW-1:0] br_tag,
  input logic          res_valid,
  input logic [NB-1:0] busy,
  input logic [NB-1:0] kill_mask,
  input logic [AW-1:0] alt_sel,
  input logic          ev_alloc,
  input logic          ev_hit,
  input logic          ev_miss,
  input logic [NQ-1:0] flush_mask,
  input logic          redir_valid,
  input logic [AW-1:0] redir_addr
);

  a_r1_alloc_marks_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ev_alloc |=> busy[$past(br_tag)]);

  a_r2_stall_blocks_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    (br_dec_valid && br_stall) |-> !ev_alloc);

  a_r4_hit_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_hit && !ev_miss) |=> (!redir_valid && flush_mask == '0));

  a_r5_miss_redirects: assert property (@(posedge clk) disable iff (!rst_n)
    ev_miss |=> (redir_valid && redir_addr == $past(alt_sel)));

  a_r6_flush_needs_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_mask != '0) |-> redir_valid);

  a_r7_killed_slots_free: assert property (@(posedge clk) disable iff (!rst_n)
    ev_miss |=> ((busy & $past(kill_mask)) == '0));

  a_r8_free_tag_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !ev_hit) |=> (!redir_valid && busy == $past(busy)));

endmodule

bind spec_branch_tagger sbt_checker #(.NB(NB), .NQ(NQ), .AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .br_dec_valid(br_dec_valid),
  .br_stall    (br_stall),
  .br_tag      (br_tag),
  .res_valid   (res_valid),
  .busy        (busy),
  .kill_mask   (kill_mask),
  .alt_sel     (alt_sel),
  .ev_alloc    (ev_alloc),
  .ev_hit      (ev_hit),
  .ev_miss     (ev_miss),
  .flush_mask  (flush_mask),
  .redir_valid (redir_valid),
  .redir_addr  (redir_addr)
);

// File: tb/spec_branch_tagger_test.sv
module spec_branch_tagger_test;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int NQ = 8;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic br_dec_valid = 0, br_dec_pred = 0;
  logic [AW-1:0] br_dec_alt = '0;
  logic [1:0] br_tag;
  logic br_stall;
  logic q_wr_valid = 0;
  logic [2:0] q_wr_idx = '0;
  logic res_valid = 0, res_taken = 0;
  logic [1:0] res_tag = '0;
  logic [NQ-1:0] flush_mask;
  logic redir_valid;
  logic [AW-1:0] redir_addr;

  int checks = 0;
  int failures = 0;

  // reference model state
  bit          m_valid [NB];
  bit          m_pred  [NB];
  logic [15:0] m_alt   [NB];
  int          m_age   [NB];
  bit          m_qt    [NQ][NB];
  int          age_ctr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spec_branch_tagger #(.NB(NB), .NQ(NQ), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n),
    .br_dec_valid(br_dec_valid), .br_dec_pred(br_dec_pred), .br_dec_alt(br_dec_alt),
    .br_tag(br_tag), .br_stall(br_stall),
    .q_wr_valid(q_wr_valid), .q_wr_idx(q_wr_idx),
    .res_valid(res_valid), .res_tag(res_tag), .res_taken(res_taken),
    .flush_mask(flush_mask), .redir_valid(redir_valid), .redir_addr(redir_addr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit dv, input bit dp, input int da,
                      input bit wv, input int wi,
                      input bit rv, input int rt, input bit rk);
    bit full, e_stall, alloc;
    int e_tag;
    bit pv [NB];
    bit kill [NB];
    logic [NQ-1:0] e_fl;
    bit e_rv;
    logic [15:0] e_ra;
    br_dec_valid = dv; br_dec_pred = dp; br_dec_alt = 16'(da);
    q_wr_valid = wv; q_wr_idx = 3'(wi);
    res_valid = rv; res_tag = 2'(rt); res_taken = rk;
    #1;
    full = 1; e_tag = -1;
    for (int b = 0; b < NB; b++) begin
      if (!m_valid[b]) begin
        full = 0;
        if (e_tag < 0) e_tag = b;
      end
    end
    e_stall = rv || full;
    chk(br_stall == e_stall, "R2", "br_stall", br_stall, e_stall);
    if (!full) chk(br_tag == 2'(e_tag), "R1", "br_tag", br_tag, e_tag);
    // next state of the model
    for (int b = 0; b < NB; b++) pv[b] = m_valid[b];
    if (wv) for (int b = 0; b < NB; b++) if (pv[b]) m_qt[wi][b] = 1;   // R3, R9
    e_fl = '0; e_rv = 0; e_ra = '0;
    if (rv && m_valid[rt]) begin
      if (rk != m_pred[rt]) begin
        e_rv = 1; e_ra = m_alt[rt];
        for (int b = 0; b < NB; b++) kill[b] = m_valid[b] && (m_age[b] >= m_age[rt]);
        for (int q = 0; q < NQ; q++) begin
          for (int b = 0; b < NB; b++) if (m_qt[q][b] && kill[b]) e_fl[q] = 1'b1;
          for (int b = 0; b < NB; b++) if (e_fl[q] || kill[b]) m_qt[q][b] = 0;
        end
        for (int b = 0; b < NB; b++) if (kill[b]) m_valid[b] = 0;     // R7
      end else begin
        for (int q = 0; q < NQ; q++) m_qt[q][rt] = 0;                  // R4
        m_valid[rt] = 0;
      end
    end
    alloc = dv && !e_stall;
    if (alloc) begin
      m_valid[e_tag] = 1; m_pred[e_tag] = dp; m_alt[e_tag] = 16'(da);
      m_age[e_tag] = age_ctr; age_ctr++;
    end
    @(posedge clk);
    @(negedge clk);
    chk(flush_mask == e_fl, "R6", "flush_mask", flush_mask, e_fl);
    chk(redir_valid == e_rv, "R5", "redir_valid", redir_valid, e_rv);
    chk(redir_addr == e_ra, "R5", "redir_addr", redir_addr, e_ra);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int b = 0; b < NB; b++) begin
      m_valid[b] = 0; m_pred[b] = 0; m_alt[b] = '0; m_age[b] = 0;
      for (int q = 0; q < NQ; q++) m_qt[q][b] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state: tag 0, no stall, no flush or redirect
    idle();

    // nested pair: correct inner, mispredicted outer (R1 R3 R4 R5 R6 R7)
    step(1, 1, 'h100, 0, 0, 0, 0, 0);   // slot 0
    step(0, 0, 0,     1, 0, 0, 0, 0);   // q0 <- {0}
    step(1, 0, 'h200, 1, 3, 0, 0, 0);   // slot 1; q3 gets only {0} (R3)
    step(0, 0, 0,     1, 2, 0, 0, 0);   // q2 <- {0,1}
    step(0, 0, 0,     1, 4, 0, 0, 0);   // q4 <- {0,1}
    step(0, 0, 0,     0, 0, 1, 1, 0);   // slot 1 correct (R4)
    step(0, 0, 0,     0, 0, 1, 0, 0);   // slot 0 wrong: flush q0 q2 q3 q4 (R5 R6)
    idle();

    // fill all slots, stall on the fifth (R2), mispredict a middle one (R7)
    step(1, 1, 'h010, 1, 1, 0, 0, 0);   // slot 0
    step(1, 0, 'h020, 1, 1, 0, 0, 0);   // slot 1, q1 <- {0}
    step(1, 1, 'h030, 1, 5, 0, 0, 0);   // slot 2, q5 <- {0,1}
    step(1, 0, 'h040, 1, 6, 0, 0, 0);   // slot 3, q6 <- {0,1,2}
    step(1, 1, 'h050, 1, 7, 0, 0, 0);   // stalled full (R2); q7 <- all
    step(1, 1, 'h060, 0, 0, 1, 2, 0);   // slot 2 wrong while announcing: kills 2,3 (R2 R7)
    step(0, 0, 0,     0, 0, 1, 3, 1);   // slot 3 is free now: ignored (R8)
    step(1, 0, 'h070, 0, 0, 0, 0, 0);   // reallocates slot 2
    step(0, 0, 0,     1, 2, 0, 0, 0);   // q2 <- {0,1,2}
    step(0, 0, 0,     0, 0, 1, 0, 1);   // slot 0 correct
    step(0, 0, 0,     0, 0, 1, 1, 1);   // slot 1 wrong: kills 1,2; flush q1? no (q1 had {0})
    idle();

    // write in the same cycle as the resolve that kills it (R9)
    step(1, 0, 'h0AA, 0, 0, 0, 0, 0);
    step(0, 0, 0,     1, 0, 1, 0, 1);   // q0 tagged then flushed
    step(1, 1, 'h0BB, 0, 0, 0, 0, 0);
    step(0, 0, 0,     1, 6, 1, 0, 1);   // correct resolve with write: q6 stays clear
    step(1, 1, 'h0CC, 0, 0, 0, 0, 0);
    step(0, 0, 0,     0, 0, 1, 0, 0);   // wrong: q6 must not flush
    step(0, 0, 0,     0, 0, 1, 2, 1);   // free slot again (R8)
    idle();
    idle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule